// File: doc/BRIEF.md
# Masked Fast GPIO Port

This block is one 32-bit general-purpose I/O port driven from a small synchronous register bus. For each pin, software chooses the direction. It can raise or lower single output bits by writing ones to a set word or a clear word, so no read-modify-write cycle is needed. A mask word removes chosen pins from pin reads and from set, clear and pin writes. The port drives a pad output and an output enable for every pin. It samples every pad through a two-flop synchronizer.

Each pin also has edge detection. A 2-bit code per pin selects no edge, falling edges, rising edges or both. A detected edge sets a sticky status bit, and software clears that bit by writing a one to it. One interrupt line is the OR of all status bits.

The bus address is a word index, so byte offset = index × 4. The index map is:

| Index | Register |
|---|---|
| 0 | direction |
| 1 to 3 | reserved |
| 4 | mask |
| 5 | pin level |
| 6 | set |
| 7 | clear |
| 8 | edge-sense word for pins 0 to 15 |
| 9 | edge-sense word for pins 16 to 31 |
| 10 | interrupt status |
| 11 to 15 | reserved |

Top module: `mgpio_port`

## Requirements
- R1: After reset, `pad_oe`, `pad_out` and `irq` are all zero. The direction, mask, sense and status registers read as zero.
- R2: Writing the direction word (index 0) sets `pad_oe` equal to the written value. A 1 bit makes that pin an output. The word reads back unchanged.
- R3: The mask word (index 4) reads back as written. A mask bit of 1 makes that bit read as 0 from the pin word and the set word. Writes to the pin, set or clear word leave that output bit unchanged.
- R4: Writing the set word (index 6) drives every unmasked output bit written as 1 high. Bits written as 0 are left unchanged. Reading the set word returns the output latch with masked bits forced to 0.
- R5: Writing the clear word (index 7) drives every unmasked output bit written as 1 low. Bits written as 0 are left unchanged. The clear word reads as 0.
- R6: Reading the pin word (index 5) returns the synchronized level of every unmasked pad, for input pins and output pins alike. Writing the pin word loads the unmasked bits of the output latch directly.
- R7: Pin i has a 2-bit sense code. For i < 16 it sits at bits [2i+1:2i] of index 8. For i ≥ 16 it sits at bits [2(i−16)+1:2(i−16)] of index 9. Code 0 disables the pin, 1 selects falling edges, 2 selects rising edges and 3 selects both. A selected edge sets that pin's status bit, and the bit stays set until it is cleared.
- R8: The status word (index 10) reads the status bits. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. `irq` is 1 whenever any status bit is 1. It rises at the third rising clock edge after the pad changes.
- R9: Reserved indices (1, 2, 3 and 11 to 15) read as 0. Writes to them change no register and no output.
- R10: `bus_rdata` shows the register addressed at the previous rising clock edge (one cycle of read latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| bus_addr | input | 4 | Register word index |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad input levels (asynchronous) |
| pad_out | output | 32 | Output latch driven to the pads |
| pad_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Combined edge interrupt |

## Verification
The write-effect properties compare each register with its value one cycle earlier. They therefore assume that `bus_we` is low while reset is asserted and during the two release cycles. The bench holds the strobe low until the internal reset has released. The bench models the pads so that an output pin reads back its own driven value, and an input pin reads a level the bench supplies. It changes those levels only between clock edges, one batch at a time, so every edge and the exact interrupt latency can be counted. The status stickiness property assumes that a bit is cleared only by a status write, and the stimulus issues such writes only as separate bus cycles.

// File: rtl/mgpio_pkg.sv
`timescale 1ns/1ps
package mgpio_pkg;
  // Edge sense code, two bits per pin
  typedef enum logic [1:0] {
    SENSE_OFF  = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_BOTH = 2'd3
  } sense_e;

  // Register word indices
  localparam int W_DIR  = 0;
  localparam int W_MASK = 4;
  localparam int W_PIN  = 5;
  localparam int W_SET  = 6;
  localparam int W_CLR  = 7;
  localparam int W_SNS  = 8;   // first sense word, further words follow
  localparam int W_STAT = 10;
endpackage

// File: rtl/mgpio_sync.sv
`timescale 1ns/1ps
module mgpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mgpio_edge.sv
`timescale 1ns/1ps
module mgpio_edge
  import mgpio_pkg::*;
#(
  parameter int N = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   lvl,
  input  logic [2*N-1:0] sense,
  input  logic [N-1:0]   clr,
  output logic [N-1:0]   status
);
  logic [N-1:0] prev_q, status_q, status_d;
  logic [N-1:0] hit, armed;

  for (genvar i = 0; i < N; i++) begin : g_pin
    sense_e code;
    logic   rise, fall;
    assign code     = sense_e'(sense[2*i +: 2]);
    assign rise     = lvl[i] & ~prev_q[i];
    assign fall     = ~lvl[i] & prev_q[i];
    assign armed[i] = (code != SENSE_OFF);
    assign hit[i]   = (rise & (code == SENSE_RISE || code == SENSE_BOTH)) |
                      (fall & (code == SENSE_FALL || code == SENSE_BOTH));
  end

  // a new edge wins over a clear in the same cycle
  always_comb status_d = (status_q & ~clr) | hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= lvl;
      status_q <= status_d;
    end
  end

  assign status = status_q;

  // R7: a set bit stays set unless a clear was requested for it
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & $past(status_q & ~clr)) == $past(status_q & ~clr)));

  // R7: a disabled pin never gains a status bit
  p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q) & ~$past(armed)) == '0));
endmodule

// File: rtl/mgpio_port.sv
`timescale 1ns/1ps
module mgpio_port
  import mgpio_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [DW-1:0]     pad_in,
  output logic [DW-1:0]     pad_out,
  output logic [DW-1:0]     pad_oe,
  output logic              irq
);
  localparam int SNS_W   = 2 * DW;
  localparam int SNS_WDS = SNS_W / DW;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [DW-1:0]    dir_q, dir_d, mask_q, mask_d, out_q, out_d;
  logic [SNS_W-1:0] sns_q, sns_d;
  logic [DW-1:0]    rdata_q, rdata_d;
  logic [DW-1:0]    pin_lvl, status, stat_clr, wr_bits;
  logic             wr_dir, wr_mask, wr_pin, wr_set, wr_clr, wr_stat, hit_rsvd;

  mgpio_sync #(.W(DW), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(pad_in), .q(pin_lvl)
  );

  mgpio_edge #(.N(DW)) u_edge (
    .clk(clk), .rst_n(rst_sync_n), .lvl(pin_lvl), .sense(sns_q),
    .clr(stat_clr), .status(status)
  );

  // decode
  assign wr_dir   = bus_we && bus_addr == ADDR_W'(W_DIR);
  assign wr_mask  = bus_we && bus_addr == ADDR_W'(W_MASK);
  assign wr_pin   = bus_we && bus_addr == ADDR_W'(W_PIN);
  assign wr_set   = bus_we && bus_addr == ADDR_W'(W_SET);
  assign wr_clr   = bus_we && bus_addr == ADDR_W'(W_CLR);
  assign wr_stat  = bus_we && bus_addr == ADDR_W'(W_STAT);
  assign wr_bits  = bus_wdata & ~mask_q;
  assign stat_clr = wr_stat ? bus_wdata : '0;
  assign hit_rsvd = (bus_addr > ADDR_W'(W_DIR) && bus_addr < ADDR_W'(W_MASK)) ||
                    (bus_addr > ADDR_W'(W_STAT));

  // next state
  always_comb begin
    dir_d  = wr_dir  ? bus_wdata : dir_q;
    mask_d = wr_mask ? bus_wdata : mask_q;
    out_d  = out_q;
    if (wr_pin) out_d = (out_q & mask_q) | wr_bits;
    if (wr_set) out_d = out_q | wr_bits;
    if (wr_clr) out_d = out_q & ~wr_bits;
    sns_d = sns_q;
    for (int k = 0; k < SNS_WDS; k++)
      if (bus_we && bus_addr == ADDR_W'(W_SNS + k)) sns_d[k*DW +: DW] = bus_wdata;
  end

  // read mux
  always_comb begin
    rdata_d = '0;
    case (bus_addr)
      ADDR_W'(W_DIR):  rdata_d = dir_q;
      ADDR_W'(W_MASK): rdata_d = mask_q;
      ADDR_W'(W_PIN):  rdata_d = pin_lvl & ~mask_q;
      ADDR_W'(W_SET):  rdata_d = out_q & ~mask_q;
      ADDR_W'(W_STAT): rdata_d = status;
      default:         rdata_d = '0;
    endcase
    for (int k = 0; k < SNS_WDS; k++)
      if (bus_addr == ADDR_W'(W_SNS + k)) rdata_d = sns_q[k*DW +: DW];
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dir_q   <= '0;
      mask_q  <= '0;
      out_q   <= '0;
      sns_q   <= '0;
      rdata_q <= '0;
    end else begin
      dir_q   <= dir_d;
      mask_q  <= mask_d;
      out_q   <= out_d;
      sns_q   <= sns_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign pad_out   = out_q;
  assign pad_oe    = dir_q;
  assign irq       = |status;

  p_dir_oe_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(wr_dir) |-> pad_oe == $past(bus_wdata));

  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(wr_pin || wr_set || wr_clr) |->
      (pad_out & $past(mask_q)) == ($past(out_q) & $past(mask_q)));

  p_set_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(wr_set) |->
      (pad_out & $past(bus_wdata & ~mask_q)) == $past(bus_wdata & ~mask_q));

  p_set_keep_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(wr_set) |-> (pad_out & $past(out_q)) == $past(out_q));

  p_clr_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(wr_clr) |-> (pad_out & $past(bus_wdata & ~mask_q)) == '0);

  p_rsvd_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(bus_we && hit_rsvd) |->
      (pad_out == $past(out_q) && pad_oe == $past(dir_q) && mask_q == $past(mask_q)));

  p_rsvd_read_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(hit_rsvd) |-> bus_rdata == '0);
endmodule

// File: tb/mgpio_port_test.sv
`timescale 1ns/1ps
module mgpio_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, pad_out, pad_oe, pad_in;
  logic [31:0] ext = '0;
  logic        irq;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  // pad model: outputs loop back, inputs take the external level
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  mgpio_port uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 4'(idx); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 4'(idx); bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;          // R10: one cycle of read latency
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 pad_out", pad_out, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(0, v);  chk("R1 dir", v, 32'h0);
    rd(4, v);  chk("R1 mask", v, 32'h0);
    rd(8, v);  chk("R1 sense", v, 32'h0);
    rd(10, v); chk("R1 status", v, 32'h0);
  endtask

  task automatic t_dir;
    logic [31:0] v;
    wr(0, 32'h0000FFFF);
    chk("R2 pad_oe", pad_oe, 32'h0000FFFF);
    rd(0, v); chk("R2 dir readback", v, 32'h0000FFFF);
    // R10: address changes every cycle, data follows one cycle later
    @(negedge clk); bus_addr = 4'd0;
    @(negedge clk); bus_addr = 4'd4;
    chk("R10 latency dir", bus_rdata, 32'h0000FFFF);
    @(negedge clk);
    chk("R10 latency mask", bus_rdata, 32'h0);
  endtask

  task automatic t_set_clr;
    logic [31:0] v;
    wr(6, 32'h000000A5); chk("R4 set", pad_out, 32'h000000A5);
    wr(6, 32'h00000100); chk("R4 zeros keep", pad_out, 32'h000001A5);
    wr(7, 32'h00000005); chk("R5 clear", pad_out, 32'h000001A0);
    rd(6, v); chk("R4 set readback", v, 32'h000001A0);
    rd(7, v); chk("R5 clear reads 0", v, 32'h0);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(4, 32'h000000F0);
    rd(4, v); chk("R3 mask readback", v, 32'h000000F0);
    wr(6, 32'h000000FF); chk("R3 masked set", pad_out, 32'h000001AF);
    wr(7, 32'h000000FF); chk("R3 masked clear", pad_out, 32'h000001A0);
    wr(5, 32'hFFFFFFFF); chk("R6 pin write masked", pad_out, 32'hFFFFFFAF);
    rd(6, v); chk("R3 set read masked", v, 32'hFFFFFF0F);
  endtask

  task automatic t_pin_read;
    logic [31:0] v;
    ext = 32'h12340000;
    idle(4);
    rd(5, v); chk("R6 pin read in+out masked", v, 32'h1234FF0F);
    wr(4, 32'h0);
    wr(5, 32'h0);
    chk("R6 pin write", pad_out, 32'h0);
    idle(4);
    rd(5, v); chk("R6 pin read after write", v, 32'h12340000);
    ext = 32'h0;
  endtask

  task automatic t_reserved;
    logic [31:0] v;
    wr(4, 32'h00000003);
    wr(1, 32'hFFFFFFFF);
    wr(3, 32'hFFFFFFFF);
    wr(11, 32'hFFFFFFFF);
    wr(15, 32'hFFFFFFFF);
    chk("R9 pad_out", pad_out, 32'h0);
    chk("R9 pad_oe", pad_oe, 32'h0000FFFF);
    rd(4, v);  chk("R9 mask kept", v, 32'h00000003);
    rd(2, v);  chk("R9 read 2", v, 32'h0);
    rd(12, v); chk("R9 read 12", v, 32'h0);
    wr(4, 32'h0);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    wr(0, 32'h0);
    ext = 32'h0;
    idle(4);
    // pin0 rise, pin1 fall, pin2 both, pin3 off; pin16 rise, pin31 fall
    wr(8, 32'h00000036);
    wr(9, 32'h40000002);
    rd(8, v); chk("R7 sense lo readback", v, 32'h00000036);
    rd(10, v); chk("R7 no edge yet", v, 32'h0);
    @(negedge clk);
    ext = 32'h0001000F;
    @(negedge clk); @(negedge clk);
    chk("R8 irq low after two edges", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 irq at third edge", {31'b0, irq}, 32'h1);
    rd(10, v); chk("R7 rising status", v, 32'h00010005);
    wr(10, 32'hFFFFFFFF);
    rd(10, v); chk("R8 clear all", v, 32'h0);
    chk("R8 irq cleared", {31'b0, irq}, 32'h0);
    ext = 32'h0;
    idle(4);
    rd(10, v); chk("R7 falling status", v, 32'h00000006);
    wr(10, 32'h00000002);
    rd(10, v); chk("R8 partial clear", v, 32'h00000004);
    chk("R8 irq still high", {31'b0, irq}, 32'h1);
    wr(10, 32'h00000004);
    chk("R8 irq low", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset;
    t_dir;
    t_set_clr;
    t_mask;
    t_pin_read;
    t_reserved;
    t_edge;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule